// File: doc/BRIEF.md
# Sixteen-Bit Auto-Reload Interval Timer

This block is a 16-bit up-counter that always runs in auto-reload mode. Software sets it up through a byte-wide register port. It writes a 16-bit reload value and a 16-bit starting count one byte at a time, then writes a control byte. The control byte starts the timer and picks the count source. When the count passes from FFFFh, the counter takes the reload value instead of wrapping to zero. A start count of FFFFh therefore reloads on the very first tick. After that the timer produces a fixed interval of 65536 minus the reload value ticks.

There are three count sources. The first advances on every system clock cycle. The second advances once every twelve system clock cycles. The third advances once every eight rising edges of an asynchronous external oscillator. That oscillator is first synchronised to the system clock and then edge-detected.

Each overflow does three things. It sets a sticky flag that only software can clear. It raises a level interrupt request when both the timer enable and the global enable are high. It sends a one-cycle start pulse to a neighbouring converter.

Top module: `tmr16_autoreload`

## Requirements
- R1: When a tick arrives while the count is FFFFh, the count takes the value of the reload register instead of 0000h. Every other tick adds one to the count.
- R2: The port decodes five addresses: 0 is control, 1 is reload low byte, 2 is reload high byte, 3 is count low byte and 4 is count high byte. Any other address reads 00h. In the control byte, bit 7 is the overflow flag, bit 2 is run, bit 1 is the fast-clock select and bit 0 is the external select. Bits 6 to 3 always read 0.
- R3: With bit 0 set, ticks come from every 8th rising edge of the external oscillator, and bit 1 has no effect. With bit 0 clear and bit 1 set, a tick occurs on every clock cycle. With both bits clear, a tick occurs once every 12 clock cycles.
- R4: An overflow sets the flag. Hardware never clears it. A write to the control byte loads the flag from bit 7 of the written data, but an overflow in the same cycle wins and leaves the flag set.
- R5: A start count of FFFFh reloads on the first tick after run is set. From then on, overflows repeat every (65536 - reload) ticks.
- R6: The interrupt request is high exactly when the flag, the timer interrupt enable and the global interrupt enable are all 1.
- R7: While run is 0, no ticks occur, the count and reload registers hold their values, and both prescalers return to zero.
- R8: The conversion start output is high for one cycle, in the cycle right after each overflow, and the flag already reads 1 in that cycle.
- R9: A byte write to the count replaces that byte and leaves the other byte unchanged. A write in the same cycle as a tick takes precedence over the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_osc | input | 1 | External oscillator, asynchronous to clk |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tmr_irq_en | input | 1 | Timer interrupt enable |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | One-cycle conversion start pulse |

## Verification
The assertions check the relations that hold on every cycle. Each overflow loads the reload value and is followed by the start pulse with the flag set. The flag never falls unless software writes the control byte. No tick occurs while stopped. The active source is the only one allowed to produce ticks. A count byte write always lands. The bench scenarios cover what only shows up across many cycles: the exact interval for each source and reload value, the external select overriding the fast select, the immediate first reload, and the values read back after a stop.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam int CNT_W = 16;

  localparam logic [2:0] ADR_CTRL   = 3'd0;
  localparam logic [2:0] ADR_RLD_LO = 3'd1;
  localparam logic [2:0] ADR_RLD_HI = 3'd2;
  localparam logic [2:0] ADR_CNT_LO = 3'd3;
  localparam logic [2:0] ADR_CNT_HI = 3'd4;

  localparam int BIT_FLAG = 7;
  localparam int BIT_RUN  = 2;
  localparam int BIT_FAST = 1;
  localparam int BIT_EXT  = 0;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_FAST = 2'd1,
    SRC_EXT  = 2'd2
  } tick_src_e;

  // external select overrides the fast/slow choice
  function automatic tick_src_e pick_src(input logic fast_sel, input logic ext_sel);
    if (ext_sel)       return SRC_EXT;
    else if (fast_sel) return SRC_FAST;
    else               return SRC_SLOW;
  endfunction

  // replace one byte of a 16-bit word
  function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] word,
                                                input logic hi,
                                                input logic [7:0] b);
    logic [CNT_W-1:0] r;
    r = word;
    if (hi) r[15:8] = b;
    else    r[7:0]  = b;
    return r;
  endfunction

  // next count value on a tick
  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] cur,
                                               input logic [CNT_W-1:0] rld);
    if (cur == {CNT_W{1'b1}}) return rld;
    else                      return cur + 1'b1;
  endfunction

endpackage

// File: rtl/tmr_ext_tick.sv
module tmr_ext_tick #(
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_DIV    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_osc,
  output logic tick
);
  localparam int DW = (EDGE_DIV > 1) ? $clog2(EDGE_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(EDGE_DIV - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [DW-1:0]          ecnt_q;
  logic                   rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_osc};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ecnt_q <= '0;
    else if (!run)    ecnt_q <= '0;
    else if (rise)    ecnt_q <= (ecnt_q == LAST) ? '0 : ecnt_q + 1'b1;
  end

  assign tick = run & rise & (ecnt_q == LAST);

  // R3
  ext_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (sync_q[SYNC_STAGES-1] && !prev_q));

endmodule

// File: rtl/tmr_pre_tick.sv
module tmr_pre_tick #(
  parameter int CLK_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = $clog2(CLK_DIV);
  localparam logic [PW-1:0] LAST = PW'(CLK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (!run) pre_q <= '0;
    else           pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  assign tick = run & (pre_q == LAST);

  // R7
  pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rld_wr_lo,
  input  logic             rld_wr_hi,
  input  logic             cnt_wr_lo,
  input  logic             cnt_wr_hi,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rld,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             cnt_wr;

  assign cnt_wr = cnt_wr_lo | cnt_wr_hi;
  assign ovf    = tick & ~cnt_wr & (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rld_q <= '0;
    else if (rld_wr_lo) rld_q <= put_byte(rld_q, 1'b0, wdata);
    else if (rld_wr_hi) rld_q <= put_byte(rld_q, 1'b1, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (cnt_wr_lo) cnt_q <= put_byte(cnt_q, 1'b0, wdata);
    else if (cnt_wr_hi) cnt_q <= put_byte(cnt_q, 1'b1, wdata);
    else if (tick)      cnt_q <= advance(cnt_q, rld_q);
  end

  assign cnt = cnt_q;
  assign rld = rld_q;

  // R1
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == $past(rld_q)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_q));

  // R9
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_lo |=> (cnt_q[7:0] == $past(wdata)));

endmodule

// File: rtl/tmr16_autoreload.sv
module tmr16_autoreload
  import tmr16_pkg::*;
#(
  parameter int SLOW_DIV    = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_osc,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tmr_irq_en,
  input  logic       glb_irq_en,
  output logic       irq,
  output logic       conv_start
);
  logic             run_q, fast_q, ext_q, flag_q, conv_q;
  logic             ctrl_wr;
  logic             slow_tick, ext_tick, tick, ovf;
  logic [CNT_W-1:0] cnt, rld;
  tick_src_e        src;

  assign ctrl_wr = reg_wr && (reg_addr == ADR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      fast_q <= 1'b0;
      ext_q  <= 1'b0;
    end else if (ctrl_wr) begin
      run_q  <= reg_wdata[BIT_RUN];
      fast_q <= reg_wdata[BIT_FAST];
      ext_q  <= reg_wdata[BIT_EXT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (ovf)     flag_q <= 1'b1;
    else if (ctrl_wr) flag_q <= reg_wdata[BIT_FLAG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_q <= 1'b0;
    else        conv_q <= ovf;
  end

  tmr_pre_tick #(.CLK_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(slow_tick));

  tmr_ext_tick #(.SYNC_STAGES(SYNC_STAGES), .EDGE_DIV(EXT_DIV)) u_ext (
    .clk(clk), .rst_n(rst_n), .run(run_q), .ext_osc(ext_osc), .tick(ext_tick));

  assign src = pick_src(fast_q, ext_q);

  always_comb begin
    case (src)
      SRC_EXT:  tick = ext_tick;
      SRC_FAST: tick = run_q;
      default:  tick = slow_tick;
    endcase
  end

  tmr_count_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .rld_wr_lo(reg_wr && (reg_addr == ADR_RLD_LO)),
    .rld_wr_hi(reg_wr && (reg_addr == ADR_RLD_HI)),
    .cnt_wr_lo(reg_wr && (reg_addr == ADR_CNT_LO)),
    .cnt_wr_hi(reg_wr && (reg_addr == ADR_CNT_HI)),
    .wdata(reg_wdata), .cnt(cnt), .rld(rld), .ovf(ovf));

  always_comb begin
    case (reg_addr)
      ADR_CTRL:   reg_rdata = {flag_q, 4'b0000, run_q, fast_q, ext_q};
      ADR_RLD_LO: reg_rdata = rld[7:0];
      ADR_RLD_HI: reg_rdata = rld[15:8];
      ADR_CNT_LO: reg_rdata = cnt[7:0];
      ADR_CNT_HI: reg_rdata = cnt[15:8];
      default:    reg_rdata = 8'h00;
    endcase
  end

  assign irq        = flag_q & tmr_irq_en & glb_irq_en;
  assign conv_start = conv_q;

  // R3
  ext_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && tick) |-> ext_tick);

  // R3
  slow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_q && !fast_q && tick) |-> slow_tick);

  // R7
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !tick);

  // R4
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ctrl_wr) |=> flag_q);

  // R8
  trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (conv_start && flag_q));

  // R6
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q && tmr_irq_en && glb_irq_en));

endmodule

// File: tb/test_tmr16_autoreload.sv
`timescale 1ns/1ps
module test_tmr16_autoreload;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_osc = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tmr_irq_en = 1'b0;
  logic       glb_irq_en = 1'b0;
  logic       irq, conv_start;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, pulses = 0, last_t = 0, prev_t = 0, ext_ph = 0;

  tmr16_autoreload i_tmr16_autoreload (
    .clk(clk), .rst_n(rst_n), .ext_osc(ext_osc), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tmr_irq_en(tmr_irq_en), .glb_irq_en(glb_irq_en), .irq(irq),
    .conv_start(conv_start));

  always #4 clk = ~clk;

  // external oscillator: period of 6 clock cycles
  always @(negedge clk) begin
    ext_ph++;
    if (ext_ph == 3) begin ext_osc <= ~ext_osc; ext_ph = 0; end
  end

  always @(negedge clk) begin
    cyc++;
    if (conv_start) begin pulses++; prev_t = last_t; last_t = cyc; end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l); rd(lo + 3'd1, h); v = {h, l};
  endtask

  function automatic int exp_period(input logic [15:0] r, input logic [7:0] c);
    int div;
    if (c[0])      div = 48;   // 8 edges, each 6 cycles apart
    else if (c[1]) div = 1;
    else           div = 12;
    return (65536 - int'(r)) * div;
  endfunction

  task automatic measure(input string req, input int exp);
    int p0, n;
    p0 = pulses; n = 0;
    while (pulses < p0 + 3 && n < 20000) begin @(posedge clk); n++; end
    if (pulses < p0 + 3) chk({req, " timeout"}, 0, 1);
    else chk(req, last_t - prev_t, exp);
  endtask

  task automatic start(input logic [15:0] r, input logic [7:0] c);
    wr(3'd0, 8'h00);
    wr(3'd1, r[7:0]); wr(3'd2, r[15:8]);
    wr(3'd3, 8'hFF);  wr(3'd4, 8'hFF);
    wr(3'd0, c);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v, v2;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state and unused address
    for (int a = 0; a < 6; a++) begin rd(3'(a), b); chk("R2 reset read", b, 0); end
    chk("R6 reset irq", irq, 0);
    chk("R8 reset conv_start", conv_start, 0);

    // R2 bits 6..3 read zero
    wr(3'd0, 8'h7A); rd(3'd0, b); chk("R2 ctrl readback", b, 8'h02);
    wr(3'd0, 8'h00);

    // R9 byte writes
    wr(3'd3, 8'h34); wr(3'd4, 8'h12); rd16(3'd3, v); chk("R9 count write", v, 16'h1234);
    wr(3'd3, 8'h99); rd16(3'd3, v); chk("R9 low byte only", v, 16'h1299);
    wr(3'd1, 8'hCD); wr(3'd2, 8'hAB); rd16(3'd1, v); chk("R2 reload write", v, 16'hABCD);

    // R5 immediate first reload, fast clock
    wr(3'd1, 8'hF6); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    wr(3'd0, 8'h06);
    @(negedge clk);
    rd16(3'd3, v); chk("R5 first tick reloads (R1)", v, 16'hFFF6);
    chk("R8 pulse after overflow", conv_start, 1);
    rd(3'd0, b); chk("R4 flag set with pulse", b, 8'h86);
    @(negedge clk);
    chk("R8 pulse one cycle", conv_start, 0);
    measure("R5 fast period", 10);

    // R7 stop keeps state; R4 flag persists
    wr(3'd0, 8'h82);
    rd16(3'd3, v); repeat (50) @(negedge clk); rd16(3'd3, v2);
    chk("R7 count frozen", v2, v);
    rd16(3'd1, v); chk("R7 reload kept", v, 16'hFFF6);
    rd(3'd0, b); chk("R4 flag never cleared by hw", b, 8'h82);
    tmr_irq_en = 1; glb_irq_en = 1; #1; chk("R6 irq both enables", irq, 1);
    glb_irq_en = 0; #1; chk("R6 irq global off", irq, 0);
    tmr_irq_en = 0; glb_irq_en = 1; #1; chk("R6 irq timer off", irq, 0);
    tmr_irq_en = 1;
    wr(3'd0, 8'h02); rd(3'd0, b); chk("R4 sw clear", b, 8'h02);
    chk("R6 irq after clear", irq, 0);
    tmr_irq_en = 0; glb_irq_en = 0;

    // R3 slow and ext (ext overrides fast select)
    start(16'hFFF6, 8'h04); measure("R3 slow period", 120);
    start(16'hFFF6, 8'h07); measure("R3 ext overrides fast", 480);
    start(16'hFFFC, 8'h05); measure("R3 ext period", 192);

    // random mix
    for (int i = 0; i < 10; i++) begin
      logic [15:0] r;
      logic [7:0]  c;
      r = 16'hFFE0 + 16'($urandom % 31);
      c = 8'h04 | 8'($urandom % 4);
      start(r, c);
      measure("R5 random period (R1 R3)", exp_period(r, c));
    end

    wr(3'd0, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule